// File: doc/BRIEF.md
# AUX Side-Channel Register Block

This block is the software-facing front end of a display AUX side channel. Software fills a small message buffer through a word-wide register port, then writes a control word that names the message length and the reply-wait limit and sets the start bit. The block hands the buffered bytes to a downstream transaction engine with a one-cycle start pulse and tracks the transfer until the engine reports completion or the reply wait runs out. On completion it loads the received bytes into the same buffer, records the received byte count in the control word, and raises status flags that software clears by writing ones.

The buffer holds `NUM_WORDS` 32-bit words (five by default, so 20 bytes). Bytes are packed most significant first: message byte k sits in word k/4 at bits [31-8*(k%4) -: 8], and word w appears on the flat engine bus at bits [BUF_W-1-32*w -: 32], so byte 0 is the top byte of the bus and a short last word is left-aligned. The reply wait is timed in microseconds by an internal prescaler; the count starts when the engine signals the end of the request and stops at the first reply edge.

A four-state machine steers the transfer. `ST_IDLE` goes to `ST_SEND` on an accepted start. `ST_SEND` goes to `ST_WAIT` on the engine's end-of-request pulse. `ST_WAIT` goes to `ST_RECV` on the first reply edge, or back to `ST_IDLE` when the wait limit expires (timeout). `ST_SEND`, `ST_WAIT` and `ST_RECV` all return to `ST_IDLE` when the engine reports completion; completion takes priority over an expiry in the same cycle.

Top module: `aux_chan_regs`

## Requirements
- R1: After reset the control word (address 0) and every data word (addresses 1 to 5) read zero, the interrupt output is low and no start pulse is issued.
- R2: While idle, a write to address 1+w stores the word in data word w and reads back unchanged; message byte k appears at eng_tx_data[159-8k -: 8], so word 0 bits 31:24 is byte 0.
- R3: An idle write to the control word with bit 31 set and a size field (bits 4:0) of 1 to 20 issues a one-cycle eng_start in the next cycle, sets busy (bit 31) and drives eng_tx_len with the size.
- R4: A start request with a size field of 0 or above 20 is ignored: busy stays low and no eng_start is issued.
- R5: While busy, writes to the control word and to the data words are ignored, including a second start, and data reads return the contents held before the transfer.
- R6: An engine completion with no error and a received count of 1 to 20 clears busy, sets done (bit 30), writes the count into the size field and loads all data words from eng_rx_data.
- R7: A completion with eng_rx_err high sets the receive-error bit (bit 27) and leaves the data words unchanged.
- R8: A completion with a received count of 0 or above 20 sets the illegal-size bit (bit 24), leaves the data words unchanged and still reports the count in the size field.
- R9: If no reply edge arrives within the selected limit after the end of the request, the transfer ends: busy clears, done and timeout-error (bit 28) set, and eng_abort pulses for one cycle. The select field (bits 26:25) picks 400, 600, 800 or 4000 microseconds for codes 0 to 3.
- R10: A reply edge stops the reply-wait timer, so a transfer that has seen one never times out.
- R11: Writing a one to done, timeout-error, receive-error or illegal-size clears that bit; writing a zero leaves it set.
- R12: The interrupt output is high exactly when done is set and the interrupt-enable bit (bit 29) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address: 0 control, 1 to 5 data words |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| irq | output | 1 | Completion interrupt |
| eng_start | output | 1 | One-cycle pulse starting an engine transfer |
| eng_abort | output | 1 | One-cycle pulse ending a timed-out transfer |
| eng_tx_len | output | 5 | Number of bytes to send |
| eng_tx_data | output | 160 | Message bytes, byte 0 in the top byte |
| eng_tx_end | input | 1 | Pulse: request fully transmitted |
| eng_reply | input | 1 | Pulse: first reply edge seen |
| eng_done | input | 1 | Pulse: transfer complete |
| eng_rx_len | input | 5 | Received byte count, valid with eng_done |
| eng_rx_err | input | 1 | Receive error, valid with eng_done |
| eng_rx_data | input | 160 | Received bytes, valid with eng_done |

## Verification
Completions are driven from a vector table that mixes clean replies of 1, 4 and 20 bytes, counts of 0, 21 and 31, and an errored reply, so a correct outcome separates the three result classes and catches an off-by-one at either size bound; a tracked copy of data word 0 shows whether a rejected reply wrongly overwrote the buffer. Start requests with sizes 0 and 21 tell a size check from a plain start bit. Timeouts are run with select codes 0, 1 and 3 and sampled a few cycles either side of the limit, which distinguishes the encodings from each other, and a transfer with an early reply edge is left waiting well past the limit to show that the timer stopped.

// File: rtl/aux_regs_pkg.sv
package aux_regs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2,
        ST_RECV = 2'd3
    } xfer_state_e;

    localparam int WORD_W         = 32;
    localparam int BYTES_PER_WORD = WORD_W / 8;

    // control word bit positions
    localparam int CB_BUSY     = 31;
    localparam int CB_DONE     = 30;
    localparam int CB_IRQEN    = 29;
    localparam int CB_TOERR    = 28;
    localparam int CB_RXERR    = 27;
    localparam int CB_TOSEL_HI = 26;
    localparam int CB_TOSEL_LO = 25;
    localparam int CB_BADLEN   = 24;

    function automatic logic len_ok(input int unsigned n, input int unsigned lim);
        return (n != 0) && (n <= lim);
    endfunction

endpackage

// File: rtl/aux_reply_timer.sv
module aux_reply_timer #(
    parameter int CYC_PER_US = 100,
    parameter int LIM_US_0   = 400,
    parameter int LIM_US_1   = 600,
    parameter int LIM_US_2   = 800,
    parameter int LIM_US_3   = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       expired
);
    localparam int MAX01  = (LIM_US_0 > LIM_US_1) ? LIM_US_0 : LIM_US_1;
    localparam int MAX23  = (LIM_US_2 > LIM_US_3) ? LIM_US_2 : LIM_US_3;
    localparam int MAXLIM = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CNT_W  = $clog2(MAXLIM + 1);

    logic             tick;
    logic [CNT_W-1:0] us_cnt;
    logic [CNT_W-1:0] limit;

    generate
        if (CYC_PER_US > 1) begin : g_prescale
            localparam int PRE_W = $clog2(CYC_PER_US);
            logic [PRE_W-1:0] pre;
            assign tick = run && (pre == PRE_W'(CYC_PER_US - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             pre <= '0;
                else if (!run || tick)  pre <= '0;
                else                    pre <= pre + PRE_W'(1);
            end
        end else begin : g_direct
            assign tick = run;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      us_cnt <= '0;
        else if (!run)   us_cnt <= '0;
        else if (tick)   us_cnt <= us_cnt + CNT_W'(1);
    end

    always_comb begin
        unique case (sel)
            2'd0: limit = CNT_W'(LIM_US_0);
            2'd1: limit = CNT_W'(LIM_US_1);
            2'd2: limit = CNT_W'(LIM_US_2);
            default: limit = CNT_W'(LIM_US_3);
        endcase
    end

    assign expired = tick && (us_cnt == limit - CNT_W'(1));

endmodule

// File: rtl/aux_msg_buffer.sv
module aux_msg_buffer #(
    parameter int NUM_WORDS = 5,
    localparam int BUF_W    = NUM_WORDS * 32,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             load,
    input  logic [BUF_W-1:0] load_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word,
    output logic [BUF_W-1:0] flat
);
    logic [31:0] words [NUM_WORDS];

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    words[w] <= '0;
                else if (load)
                    words[w] <= load_data[BUF_W-1-32*w -: 32];
                else if (wr_en && !busy && (wr_idx == IDX_W'(w)))
                    words[w] <= wr_data;
            end
            assign flat[BUF_W-1-32*w -: 32] = words[w];
        end
    endgenerate

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_WORDS; i++)
            if (rd_idx == IDX_W'(i)) rd_word = words[i];
    end

    // R5: a transfer in flight never sees its buffer change except by the reply load
    assert_hold_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> $stable(flat));

endmodule

// File: rtl/aux_xfer_fsm.sv
module aux_xfer_fsm
    import aux_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_req,
    input  logic        tx_end,
    input  logic        reply,
    input  logic        done_in,
    input  logic        expired,
    output xfer_state_e state,
    output logic        busy,
    output logic        timer_run,
    output logic        complete,
    output logic        timeout,
    output logic        start_pulse,
    output logic        abort_pulse
);
    xfer_state_e state_nx;

    assign busy      = (state != ST_IDLE);
    assign timer_run = (state == ST_WAIT);
    assign complete  = busy && done_in;
    assign timeout   = (state == ST_WAIT) && expired && !done_in;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_req) state_nx = ST_SEND;
            ST_SEND: begin
                if (complete)      state_nx = ST_IDLE;
                else if (tx_end)   state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (complete)      state_nx = ST_IDLE;
                else if (timeout)  state_nx = ST_IDLE;
                else if (reply)    state_nx = ST_RECV;
            end
            ST_RECV: if (complete) state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            start_pulse <= (state == ST_IDLE) && start_req;
            abort_pulse <= timeout;
        end
    end

    assert_start_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    assert_start_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (state == ST_SEND));

    assert_timer_stops_at_reply_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WAIT) && reply && !done_in && !expired) |=> (state == ST_RECV));

endmodule

// File: rtl/aux_chan_regs.sv
module aux_chan_regs
    import aux_regs_pkg::*;
#(
    parameter int NUM_WORDS  = 5,
    parameter int CYC_PER_US = 100,
    parameter int TO_US_0    = 400,
    parameter int TO_US_1    = 600,
    parameter int TO_US_2    = 800,
    parameter int TO_US_3    = 4000,
    localparam int BUF_W     = NUM_WORDS * 32,
    localparam int MAX_BYTES = NUM_WORDS * BYTES_PER_WORD,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1),
    localparam int ADDR_W    = $clog2(NUM_WORDS + 1),
    localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              eng_start,
    output logic              eng_abort,
    output logic [LEN_W-1:0]  eng_tx_len,
    output logic [BUF_W-1:0]  eng_tx_data,
    input  logic              eng_tx_end,
    input  logic              eng_reply,
    input  logic              eng_done,
    input  logic [LEN_W-1:0]  eng_rx_len,
    input  logic              eng_rx_err,
    input  logic [BUF_W-1:0]  eng_rx_data
);
    // control word state
    logic             ctl_done;
    logic             ctl_irq_en;
    logic             ctl_to_err;
    logic             ctl_rx_err;
    logic             ctl_bad_len;
    logic [1:0]       ctl_to_sel;
    logic [LEN_W-1:0] ctl_size;

    xfer_state_e      state;
    logic             busy;
    logic             timer_run;
    logic             complete;
    logic             timeout;
    logic             expired;

    logic             ctl_wr;
    logic             data_sel;
    logic [IDX_W-1:0] word_idx;
    logic             start_req;
    logic             rx_legal;
    logic             buf_load;
    logic [31:0]      buf_rd;
    logic [31:0]      ctl_rdata;
    logic             unused_wbits;

    assign ctl_wr    = bus_wr && (bus_addr == '0);
    assign data_sel  = (bus_addr != '0) && (int'(bus_addr) <= NUM_WORDS);
    assign word_idx  = IDX_W'(bus_addr - ADDR_W'(1));
    assign start_req = ctl_wr && !busy && bus_wdata[CB_BUSY]
                       && len_ok(int'(bus_wdata[LEN_W-1:0]), MAX_BYTES);
    assign rx_legal  = len_ok(int'(eng_rx_len), MAX_BYTES);
    assign buf_load  = complete && !eng_rx_err && rx_legal;
    assign unused_wbits = ^bus_wdata[CB_BADLEN-1:LEN_W];

    aux_xfer_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .tx_end      (eng_tx_end),
        .reply       (eng_reply),
        .done_in     (eng_done),
        .expired     (expired),
        .state       (state),
        .busy        (busy),
        .timer_run   (timer_run),
        .complete    (complete),
        .timeout     (timeout),
        .start_pulse (eng_start),
        .abort_pulse (eng_abort)
    );

    aux_reply_timer #(
        .CYC_PER_US (CYC_PER_US),
        .LIM_US_0   (TO_US_0),
        .LIM_US_1   (TO_US_1),
        .LIM_US_2   (TO_US_2),
        .LIM_US_3   (TO_US_3)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .sel     (ctl_to_sel),
        .expired (expired)
    );

    aux_msg_buffer #(.NUM_WORDS(NUM_WORDS)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .wr_en     (bus_wr && data_sel),
        .wr_idx    (word_idx),
        .wr_data   (bus_wdata),
        .load      (buf_load),
        .load_data (eng_rx_data),
        .rd_idx    (word_idx),
        .rd_word   (buf_rd),
        .flat      (eng_tx_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_done    <= 1'b0;
            ctl_irq_en  <= 1'b0;
            ctl_to_err  <= 1'b0;
            ctl_rx_err  <= 1'b0;
            ctl_bad_len <= 1'b0;
            ctl_to_sel  <= 2'd0;
            ctl_size    <= '0;
        end else if (complete) begin
            ctl_done <= 1'b1;
            ctl_size <= eng_rx_len;
            if (eng_rx_err)     ctl_rx_err  <= 1'b1;
            else if (!rx_legal) ctl_bad_len <= 1'b1;
        end else if (timeout) begin
            ctl_done   <= 1'b1;
            ctl_to_err <= 1'b1;
        end else if (ctl_wr && !busy) begin
            ctl_irq_en <= bus_wdata[CB_IRQEN];
            ctl_to_sel <= bus_wdata[CB_TOSEL_HI:CB_TOSEL_LO];
            ctl_size   <= bus_wdata[LEN_W-1:0];
            if (bus_wdata[CB_DONE])   ctl_done    <= 1'b0;
            if (bus_wdata[CB_TOERR])  ctl_to_err  <= 1'b0;
            if (bus_wdata[CB_RXERR])  ctl_rx_err  <= 1'b0;
            if (bus_wdata[CB_BADLEN]) ctl_bad_len <= 1'b0;
        end
    end

    assign ctl_rdata = {busy, ctl_done, ctl_irq_en, ctl_to_err, ctl_rx_err,
                        ctl_to_sel, ctl_bad_len, {(CB_BADLEN-LEN_W){1'b0}}, ctl_size};

    assign bus_rdata  = (bus_addr == '0) ? ctl_rdata : (data_sel ? buf_rd : 32'd0);
    assign irq        = ctl_done && ctl_irq_en;
    assign eng_tx_len = ctl_size;

    assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && busy) |=> (!busy && ctl_done));

    assert_abort_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> (ctl_to_err && ctl_done && !busy));

    assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_wr && !eng_done) |=> ($stable(ctl_irq_en) && $stable(ctl_to_sel)));

    assert_bad_len_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && !rx_legal) |=> $stable(eng_tx_data));

endmodule

// File: tb/test_aux_chan_regs.sv
module test_aux_chan_regs;
    localparam int CLK_PERIOD = 10;

    localparam logic [31:0] M_BUSY  = 32'h8000_0000;
    localparam logic [31:0] M_DONE  = 32'h4000_0000;
    localparam logic [31:0] M_IRQEN = 32'h2000_0000;
    localparam logic [31:0] M_TOERR = 32'h1000_0000;
    localparam logic [31:0] M_RXERR = 32'h0800_0000;
    localparam logic [31:0] M_BAD   = 32'h0100_0000;
    localparam logic [31:0] M_W1C   = 32'h5900_0000;

    // vector table: bit 5 = receive error, bits 4:0 = received count
    localparam logic [5:0] VEC [0:6] = '{6'h04, 6'h14, 6'h01, 6'h00, 6'h15, 6'h1F, 6'h28};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = 3'd0;
    logic [31:0]  bus_wdata = 32'd0;
    logic [31:0]  bus_rdata;
    logic         irq;
    logic         eng_start;
    logic         eng_abort;
    logic [4:0]   eng_tx_len;
    logic [159:0] eng_tx_data;
    logic         eng_tx_end = 1'b0;
    logic         eng_reply = 1'b0;
    logic         eng_done = 1'b0;
    logic [4:0]   eng_rx_len = 5'd0;
    logic         eng_rx_err = 1'b0;
    logic [159:0] eng_rx_data = '0;

    int checks = 0;
    int errors = 0;
    int abort_cnt = 0;
    bit finished = 1'b0;
    logic [31:0] model_w0;
    logic [31:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_chan_regs #(.CYC_PER_US(1)) i_aux_chan_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .eng_start(eng_start), .eng_abort(eng_abort), .eng_tx_len(eng_tx_len),
        .eng_tx_data(eng_tx_data), .eng_tx_end(eng_tx_end), .eng_reply(eng_reply),
        .eng_done(eng_done), .eng_rx_len(eng_rx_len), .eng_rx_err(eng_rx_err),
        .eng_rx_data(eng_rx_data)
    );

    always @(negedge clk) if (eng_abort) abort_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_tx_end();
        @(negedge clk); eng_tx_end = 1'b1;
        @(negedge clk); eng_tx_end = 1'b0;
    endtask

    task automatic pulse_reply();
        @(negedge clk); eng_reply = 1'b1;
        @(negedge clk); eng_reply = 1'b0;
    endtask

    task automatic finish_xfer(input logic [4:0] len, input logic err, input logic [159:0] d);
        @(negedge clk);
        eng_done = 1'b1; eng_rx_len = len; eng_rx_err = err; eng_rx_data = d;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(3'd0, v); chk("R1 control word", v, 32'd0);
        for (int a = 1; a <= 5; a++) begin
            rd(3'(a), v); chk("R1 data word", v, 32'd0);
        end
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 eng_start", {31'd0, eng_start}, 32'd0);

        // R2: data words and byte order
        wr(3'd1, 32'h1122_3344);
        wr(3'd2, 32'h5566_7788);
        wr(3'd5, 32'hAABB_CCDD);
        rd(3'd1, v); chk("R2 word0 readback", v, 32'h1122_3344);
        rd(3'd5, v); chk("R2 word4 readback", v, 32'hAABB_CCDD);
        chk("R2 byte0 at top", {24'd0, eng_tx_data[159:152]}, 32'h11);
        chk("R2 byte4 position", {24'd0, eng_tx_data[127:120]}, 32'h55);
        chk("R2 byte19 position", {24'd0, eng_tx_data[7:0]}, 32'hDD);
        model_w0 = 32'h1122_3344;

        // R4: illegal send sizes ignored
        wr(3'd0, M_BUSY | 32'd0);
        chk("R4 size 0 no start", {31'd0, eng_start}, 32'd0);
        rd(3'd0, v); chk("R4 size 0 not busy", v & M_BUSY, 32'd0);
        wr(3'd0, M_BUSY | 32'd21);
        chk("R4 size 21 no start", {31'd0, eng_start}, 32'd0);
        rd(3'd0, v); chk("R4 size 21 not busy", v & M_BUSY, 32'd0);

        // R3: accepted start
        wr(3'd0, M_BUSY | M_IRQEN | 32'd7);
        chk("R3 start pulse", {31'd0, eng_start}, 32'd1);
        chk("R3 tx len", {27'd0, eng_tx_len}, 32'd7);
        rd(3'd0, v);
        chk("R3 start pulse one cycle", {31'd0, eng_start}, 32'd0);
        chk("R3 busy set", v & M_BUSY, M_BUSY);

        // R5: writes while busy ignored
        wr(3'd1, 32'hDEAD_BEEF);
        rd(3'd1, v); chk("R5 data write ignored", v, 32'h1122_3344);
        wr(3'd0, M_BUSY | 32'd3);
        chk("R5 restart ignored", {31'd0, eng_start}, 32'd0);
        chk("R5 tx len kept", {27'd0, eng_tx_len}, 32'd7);
        rd(3'd0, v); chk("R5 irq enable kept", v & M_IRQEN, M_IRQEN);

        pulse_tx_end();
        pulse_reply();
        finish_xfer(5'd7, 1'b0, {5{32'h0BAD_F00D}});
        model_w0 = 32'h0BAD_F00D;
        rd(3'd0, v); chk("R6 first completion", v, M_DONE | M_IRQEN | 32'd7);
        rd(3'd1, v); chk("R6 first load", v, model_w0);

        // R11: write zero leaves done, write one clears
        wr(3'd0, M_IRQEN | 32'd7);
        rd(3'd0, v); chk("R11 zero keeps done", v & M_DONE, M_DONE);
        chk("R12 irq with done", {31'd0, irq}, 32'd1);
        wr(3'd0, M_IRQEN | M_DONE | 32'd7);
        rd(3'd0, v); chk("R11 one clears done", v & M_DONE, 32'd0);
        chk("R12 irq cleared", {31'd0, irq}, 32'd0);

        // vector table of completions: R6, R7, R8, R12
        for (int i = 0; i < 7; i++) begin
            logic        err;
            logic [4:0]  len;
            logic        legal;
            logic [31:0] pat;
            logic [31:0] exp_ctl;
            string       tag;
            err   = VEC[i][5];
            len   = VEC[i][4:0];
            legal = !err && (len != 5'd0) && (len <= 5'd20);
            pat   = 32'hC0DE_0000 + 32'(i);
            exp_ctl = M_DONE | M_IRQEN | 32'(len)
                      | (err ? M_RXERR : 32'd0) | ((!err && !legal) ? M_BAD : 32'd0);
            tag = err ? "R7" : (legal ? "R6" : "R8");
            wr(3'd0, M_BUSY | M_W1C | M_IRQEN | 32'd4);
            pulse_tx_end();
            pulse_reply();
            finish_xfer(len, err, {5{pat}});
            if (legal) model_w0 = pat;
            rd(3'd0, v); chk({tag, " control after completion"}, v, exp_ctl);
            rd(3'd1, v); chk({tag, " data word0"}, v, model_w0);
            if (legal) begin
                rd(3'd5, v); chk("R6 data word4", v, pat);
            end
            chk("R12 irq on completion", {31'd0, irq}, 32'd1);
        end

        // R9: timeout, select 0 (400)
        wr(3'd0, M_BUSY | M_W1C | M_IRQEN | 32'd3);
        pulse_tx_end();
        repeat (395) @(negedge clk);
        rd(3'd0, v); chk("R9 sel0 still busy", v & M_BUSY, M_BUSY);
        repeat (8) @(negedge clk);
        rd(3'd0, v); chk("R9 sel0 timed out", v, M_DONE | M_IRQEN | M_TOERR | 32'd3);
        chk("R9 abort pulse count", 32'(abort_cnt), 32'd1);
        wr(3'd0, M_IRQEN | M_TOERR | 32'd3);
        rd(3'd0, v); chk("R11 clear timeout", v & M_TOERR, 32'd0);

        // R9: select 1 (600), interrupt disabled
        wr(3'd0, M_BUSY | M_W1C | (32'd1 << 25) | 32'd3);
        pulse_tx_end();
        repeat (595) @(negedge clk);
        rd(3'd0, v); chk("R9 sel1 still busy", v & M_BUSY, M_BUSY);
        repeat (8) @(negedge clk);
        rd(3'd0, v); chk("R9 sel1 timed out", v, M_DONE | M_TOERR | (32'd1 << 25) | 32'd3);
        chk("R12 irq off when disabled", {31'd0, irq}, 32'd0);

        // R9: select 3 (4000)
        wr(3'd0, M_BUSY | M_W1C | (32'd3 << 25) | 32'd3);
        pulse_tx_end();
        repeat (3995) @(negedge clk);
        rd(3'd0, v); chk("R9 sel3 still busy", v & M_BUSY, M_BUSY);
        repeat (8) @(negedge clk);
        rd(3'd0, v); chk("R9 sel3 timed out", v & (M_BUSY | M_TOERR), M_TOERR);
        chk("R9 abort pulse total", 32'(abort_cnt), 32'd3);

        // R10: reply edge stops timer
        wr(3'd0, M_BUSY | M_W1C | 32'd3);
        pulse_tx_end();
        repeat (10) @(negedge clk);
        pulse_reply();
        repeat (700) @(negedge clk);
        rd(3'd0, v); chk("R10 no timeout after reply", v & (M_BUSY | M_TOERR), M_BUSY);
        finish_xfer(5'd2, 1'b0, {5{32'h1234_5678}});
        rd(3'd0, v); chk("R10 completes normally", v, M_DONE | 32'd2);
        chk("R10 no extra abort", 32'(abort_cnt), 32'd3);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule